// File: doc/BRIEF.md
# Keyed Deadman Timer

This block is a deadman timer for safety-critical software. Its counter does not run on every clock. It advances only on an instruction-fetch strobe, so it measures how much code has executed since the last service. Software must service the timer with a two-step keyed clear. The first step writes an arming key. Once the count has passed a programmed window threshold, the second step writes a clear key. This returns the count to zero and closes the window.

Any of the following raises a sticky reset request and sets the deadman bit in a reset-cause output:

- the count reaching the programmed timeout value;
- a wrong key in either step;
- a clear attempt made out of order.

Software sees a status word with four flags:

- the window is open;
- a timeout event has occurred;
- bad flag 1, set by a wrong key;
- bad flag 2, set by a clear attempt that is out of order or too early.

The timer is programmed through a simple register port. Each write takes effect at the clock edge. The read data is a combinational decode of the address.

Top module: `deadman_keyed`

## Requirements
- R1: After reset the timer is disabled. Control, status and count read 0x0, the timeout register reads TMO_INIT, the window register reads WIN_INIT, `rstReq` is 0 and `causeReg` is 0x00.
- R2: Writing control (offset 0x00) with bit 15 set enables the timer. While enabled and not faulted, each cycle with `fetchStb` high adds one to the count (offset 0x40). While disabled the count stays at 0.
- R3: Status bit 0 (offset 0x30) reads 1 exactly when the timer is enabled and the count is greater than or equal to the window value (offset 0x70).
- R4: When the count reaches the timeout value (offset 0x60), status bit 5 sets on the next edge and `rstReq` rises. After that the count no longer advances.
- R5: The clear sequence has two writes. The first writes 0x40 in bits 15:8 at offset 0x10. The second writes 0x08 in bits 7:0 at offset 0x20 while the window is open. Together they return the count to 0, close the window and leave status bits 5, 6 and 7 at 0.
- R6: Either of these sets status bit 7 (bad flag 1) and raises `rstReq`: a first-step write whose bits 15:8 are not 0x40, or a second-step write with a wrong key made after arming while the window is open.
- R7: A second-step write sets status bit 6 (bad flag 2) and raises `rstReq` if no first step preceded it, or if the window is not yet open.
- R8: Once `rstReq` is high, `causeReg` bit 5 is set on the next edge and stays set until reset. All other `causeReg` bits read 0.
- R9: Once the timer is enabled, a control write with bit 15 clear is ignored unless `dbgAllow` is high. With `dbgAllow` high it disables the timer and the count returns to 0.
- R10: The timeout and window registers accept writes only while the timer is disabled. Writes while enabled are ignored.
- R11: Key writes while the timer is disabled change nothing. The timeout and bad flags stay set until reset, even if a correct sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchStb | input | 1 | One pulse per executed instruction fetch |
| dbgAllow | input | 1 | Permits disabling the timer once it is enabled |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| rstReq | output | 1 | Sticky system reset request |
| causeReg | output | 8 | Reset-cause flags; bit 5 marks a deadman reset |

## Verification
Every cycle, the assertions check the following:

- the count never passes the timeout value;
- the count steps by exactly one on a counted strobe;
- both bad flags are sticky;
- the enable holds unless debug access is allowed;
- the cause bit follows a reset request.

The ordering rules themselves can only be shown by the bench's scenarios. Those rules are where a clear is early, unarmed, mis-keyed or correct, and whether the window flag tracks the programmed threshold. To cover them, the bench sweeps every clear point below the timeout for several window and timeout settings, and every small timeout value.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  // Register byte offsets (software-visible map)
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_ARM  = 8'h10;
  localparam logic [7:0] OFS_KICK = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_CNT  = 8'h40;
  localparam logic [7:0] OFS_TMO  = 8'h60;
  localparam logic [7:0] OFS_WIN  = 8'h70;

  // Key values
  localparam logic [7:0] KEY_ARM  = 8'h40;
  localparam logic [7:0] KEY_KICK = 8'h08;

  // Bit positions
  localparam int EN_BIT    = 15;
  localparam int ST_WIN    = 0;
  localparam int ST_EVT    = 5;
  localparam int ST_BAD2   = 6;
  localparam int ST_BAD1   = 7;
  localparam int CAUSE_BIT = 5;

  // Control-to-datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntStep;
    logic tmoLoad;
    logic winLoad;
  } dmtStrobe_t;
endpackage

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TMO_INIT = 1000,
  parameter int WIN_INIT = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  dmtStrobe_t       strobe,
  input  logic [CNT_W-1:0] ldVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] tmoLimit,
  output logic [CNT_W-1:0] winLimit,
  output logic             winOpen,
  output logic             tmoReached
);
  localparam logic [CNT_W-1:0] TMO_RST = CNT_W'(TMO_INIT);
  localparam logic [CNT_W-1:0] WIN_RST = CNT_W'(WIN_INIT);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobe.cntClr) begin
      count <= '0;
    end else if (strobe.cntStep) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmoLimit <= TMO_RST;
      winLimit <= WIN_RST;
    end else begin
      if (strobe.tmoLoad) tmoLimit <= ldVal;
      if (strobe.winLoad) winLimit <= ldVal;
    end
  end

  assign winOpen    = (count >= winLimit);
  assign tmoReached = (count >= tmoLimit);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= tmoLimit);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.cntStep && !strobe.cntClr) |=> (count == $past(count) + ONE));
endmodule

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fetchStb,
  input  logic              dbgAllow,
  input  logic              winOpen,
  input  logic              tmoReached,
  output dmtStrobe_t        strobe,
  output logic              en,
  output logic              evt,
  output logic              bad1,
  output logic              bad2,
  output logic              rstReq,
  output logic              causeBit
);
  logic armed, faulted;
  logic ctrlWr, armWr, kickWr, armKeyOk, kickKeyOk;
  logic kickSeqErr, kickKeyErr, kickOk;

  assign faulted   = evt | bad1 | bad2;
  assign ctrlWr    = wrEn && (addr == OFS_CTRL);
  assign armWr     = wrEn && (addr == OFS_ARM)  && en && !faulted;
  assign kickWr    = wrEn && (addr == OFS_KICK) && en && !faulted;
  assign armKeyOk  = (wrData[15:8] == KEY_ARM);
  assign kickKeyOk = (wrData[7:0] == KEY_KICK);

  assign kickSeqErr = kickWr && (!armed || !winOpen);
  assign kickKeyErr = kickWr && armed && winOpen && !kickKeyOk;
  assign kickOk     = kickWr && armed && winOpen && kickKeyOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
    end else if (ctrlWr) begin
      if (wrData[EN_BIT]) en <= 1'b1;
      else if (dbgAllow)  en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (!en || faulted || kickWr) begin
      armed <= 1'b0;
    end else if (armWr && armKeyOk) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt      <= 1'b0;
      bad1     <= 1'b0;
      bad2     <= 1'b0;
      causeBit <= 1'b0;
    end else begin
      evt      <= evt  | (en && tmoReached);
      bad1     <= bad1 | (armWr && !armKeyOk) | kickKeyErr;
      bad2     <= bad2 | kickSeqErr;
      causeBit <= causeBit | faulted;
    end
  end

  assign rstReq = faulted;

  always_comb begin
    strobe.cntClr  = !en || kickOk;
    strobe.cntStep = en && fetchStb && !tmoReached && !faulted;
    strobe.tmoLoad = !en && wrEn && (addr == OFS_TMO);
    strobe.winLoad = !en && wrEn && (addr == OFS_WIN);
  end

  // R6
  bad1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bad1 |=> bad1);

  // R7
  bad2_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bad2 |=> bad2);

  // R9
  en_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !dbgAllow) |=> en);

  // R8
  cause_set_chk: assert property (@(posedge clk) disable iff (rst)
    rstReq |=> causeBit);
endmodule

// File: rtl/deadman_keyed.sv
module deadman_keyed
  import dmt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int TMO_INIT = 1000,
  parameter int WIN_INIT = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchStb,
  input  logic              dbgAllow,
  input  logic              wrEn,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic [7:0]        causeReg
);
  dmtStrobe_t       strobe;
  logic [CNT_W-1:0] count, tmoLimit, winLimit;
  logic             winOpen, tmoReached, en, evt, bad1, bad2, causeBit;

  dmt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .fetchStb(fetchStb), .dbgAllow(dbgAllow), .winOpen(winOpen),
    .tmoReached(tmoReached), .strobe(strobe), .en(en), .evt(evt),
    .bad1(bad1), .bad2(bad2), .rstReq(rstReq), .causeBit(causeBit)
  );

  dmt_datapath #(.CNT_W(CNT_W), .TMO_INIT(TMO_INIT), .WIN_INIT(WIN_INIT)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .ldVal(wrData[CNT_W-1:0]),
    .count(count), .tmoLimit(tmoLimit), .winLimit(winLimit),
    .winOpen(winOpen), .tmoReached(tmoReached)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_CTRL: rdData[EN_BIT] = en;
      OFS_STAT: begin
        rdData[ST_WIN]  = en && winOpen;
        rdData[ST_EVT]  = evt;
        rdData[ST_BAD2] = bad2;
        rdData[ST_BAD1] = bad1;
      end
      OFS_CNT:  rdData[CNT_W-1:0] = count;
      OFS_TMO:  rdData[CNT_W-1:0] = tmoLimit;
      OFS_WIN:  rdData[CNT_W-1:0] = winLimit;
      default:  rdData = '0;
    endcase
  end

  always_comb begin
    causeReg = '0;
    causeReg[CAUSE_BIT] = causeBit;
  end

  // R4
  frozen_after_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rstReq && en && !(wrEn && addr == OFS_CTRL)) |=> $stable(count));
endmodule

// File: tb/deadman_keyed_bench.sv
module deadman_keyed_bench;
  localparam int CNT_W = 8;
  localparam int DATA_W = 32;
  localparam int TMO_INIT = 200;
  localparam int WIN_INIT = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchStb = 1'b0;
  logic dbgAllow = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic rstReq;
  logic [7:0] causeReg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  deadman_keyed #(.CNT_W(CNT_W), .DATA_W(DATA_W), .TMO_INIT(TMO_INIT), .WIN_INIT(WIN_INIT))
    u_deadman_keyed (.clk(clk), .rst(rst), .fetchStb(fetchStb), .dbgAllow(dbgAllow),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .rstReq(rstReq), .causeReg(causeReg));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; wrEn = 1'b0; fetchStb = 1'b0; dbgAllow = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic fetch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fetchStb = 1'b1;
    end
    @(negedge clk); fetchStb = 1'b0;
  endtask

  task automatic setup(input int win, input int tmo);
    doReset();
    wr(8'h70, 32'(win));
    wr(8'h60, 32'(tmo));
    wr(8'h00, 32'h8000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    doReset();
    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h30, v); check("R1 status", v, 0);
    rd(8'h40, v); check("R1 count", v, 0);
    rd(8'h60, v); check("R1 tmo", v, TMO_INIT);
    rd(8'h70, v); check("R1 win", v, WIN_INIT);
    check("R1 rstReq", rstReq, 0);
    check("R1 cause", causeReg, 0);

    // R2 disabled: strobes do not count; R11 keys ignored when disabled
    fetch(5);
    rd(8'h40, v); check("R2 count while disabled", v, 0);
    wr(8'h10, 32'h0000_1100);
    wr(8'h20, 32'h0000_0001);
    rd(8'h30, v); check("R11 keys ignored while disabled", v, 0);
    check("R11 no reset request", rstReq, 0);

    // R3 R5 R7 sweep: every clear point below timeout
    for (int win = 1; win <= 3; win++) begin
      for (int c = 0; c < win + 3; c++) begin
        setup(win, win + 3);
        fetch(c);
        rd(8'h40, v); check("R2 count after strobes", v, c);
        rd(8'h30, v); check("R3 window flag", v, (c >= win) ? 1 : 0);
        wr(8'h10, 32'h0000_4000);
        wr(8'h20, 32'h0000_0008);
        rd(8'h30, v);
        if (c >= win) begin
          check("R5 status after clear", v, 0);
          rd(8'h40, v); check("R5 count after clear", v, 0);
          check("R5 no reset request", rstReq, 0);
        end else begin
          check("R7 early clear sets bad2", v, 32'h40);
          check("R7 reset request", rstReq, 1);
        end
      end
    end

    // R4 R8 timeout sweep
    for (int tmo = 1; tmo <= 5; tmo++) begin
      setup(tmo, tmo);
      fetch(tmo);
      @(negedge clk);
      rd(8'h30, v); check("R4 timeout event", v & 32'h20, 32'h20);
      check("R4 reset request", rstReq, 1);
      @(negedge clk);
      check("R8 cause bit 5", causeReg, 8'h20);
      fetch(3);
      rd(8'h40, v); check("R4 count frozen", v, tmo);
    end

    // R6 wrong first key
    setup(2, 10);
    wr(8'h10, 32'h0000_4100);
    rd(8'h30, v); check("R6 bad arm key", v, 32'h80);
    check("R6 reset request", rstReq, 1);

    // R6 wrong second key after arming with window open
    setup(2, 10);
    fetch(3);
    wr(8'h10, 32'h0000_4000);
    wr(8'h20, 32'h0000_0009);
    rd(8'h30, v); check("R6 bad clear key", v, 32'h81);
    // R11 flags stay after a correct sequence
    wr(8'h10, 32'h0000_4000);
    wr(8'h20, 32'h0000_0008);
    rd(8'h30, v); check("R11 flag sticky", v, 32'h81);

    // R7 clear without arming, window open
    setup(2, 10);
    fetch(3);
    wr(8'h20, 32'h0000_0008);
    rd(8'h30, v); check("R7 unarmed clear", v, 32'h41);

    // R9 R10 lock and debug disable
    setup(2, 10);
    fetch(4);
    wr(8'h00, 32'h0);
    rd(8'h00, v); check("R9 enable locked", v, 32'h8000);
    wr(8'h60, 32'd50);
    rd(8'h60, v); check("R10 tmo write ignored", v, 10);
    wr(8'h70, 32'd7);
    rd(8'h70, v); check("R10 win write ignored", v, 2);
    dbgAllow = 1'b1;
    wr(8'h00, 32'h0);
    dbgAllow = 1'b0;
    rd(8'h00, v); check("R9 debug disable", v, 0);
    @(negedge clk);
    rd(8'h40, v); check("R9 count cleared", v, 0);
    wr(8'h60, 32'd50);
    rd(8'h60, v); check("R10 tmo write while disabled", v, 50);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule